// File: doc/BRIEF.md
# Context-Synchronizing Fetch Flush Controller

This block sits in the front end of a simple in-order core and carries out a context-synchronizing instruction. When decode presents the sync instruction, the block stalls issue of every younger instruction. It then waits for the backend's count of in-flight older instructions to fall to zero. It does not wait for the memory accesses those instructions started. Once the count is zero, it discards the prefetch queue for one cycle and aborts every outstanding uncacheable instruction fetch. Finally it steers fetch to the word after the sync instruction. Younger code is therefore fetched again under the context that the older code established.

Outstanding fetches are tagged with a generation number that the block publishes. At the flush, the generation moves on by one. From then on, an uncacheable response that carries an older generation is stale and never reaches decode. Cacheable responses belong to line fills, which are allowed to finish, so they are always passed on. A second sync request that arrives while the block is busy is held off by a low ready. It is not queued. The block alters no architected register. The condition field that the instruction leaves undefined is not touched here.

Top module: `fetch_sync_ctrl`

## Requirements
- R1: `sync_req_ready` is 1 only while the controller is idle. A request is accepted only when `sync_req_valid` and `sync_req_ready` are both 1. A request made while not ready has no effect: it does not change the redirect target or start another flush.
- R2: `sync_busy` is 1 in the cycle a request is presented, and stays 1 from acceptance through the redirect cycle. `issue_ok` equals `issue_valid` while `sync_busy` is 0 and is 0 while `sync_busy` is 1.
- R3: While the in-flight count is non-zero, the controller stays in its drain phase and asserts neither `pfq_flush` nor `unc_abort`.
- R4: `pfq_flush` and `unc_abort` are 1 together for exactly one cycle. That cycle is the one after the first drain cycle in which `inflight_cnt` is 0.
- R5: `redirect_valid` is 1 for exactly the one cycle after the flush cycle. In that cycle `redirect_pc` equals the accepted request PC plus 4, modulo 2^AW.
- R6: `cur_gen` is 0 after reset and steps up by 1, modulo 2^GW, at the end of each flush cycle. It does not change at any other time.
- R7: An uncacheable response (`rsp_cacheable` = 0) is forwarded only if its `rsp_gen` equals `cur_gen` and the current cycle is not the flush cycle. Otherwise `rsp_fwd_valid` stays 0.
- R8: A cacheable response (`rsp_cacheable` = 1) is always forwarded, whatever its generation and whatever the controller's phase. When `rsp_fwd_valid` is 1, `rsp_fwd_data` equals `rsp_data`.
- R9: After reset the controller is idle: ready 1, busy 0, flush 0, abort 0, redirect 0, generation 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req_valid | input | 1 | Decode presents a sync instruction |
| sync_req_pc | input | AW | PC of the sync instruction |
| sync_req_ready | output | 1 | Controller can accept a request |
| inflight_cnt | input | CW | Older instructions still executing in the backend |
| issue_valid | input | 1 | Decode wants to issue a younger instruction |
| issue_ok | output | 1 | Issue permitted this cycle |
| sync_busy | output | 1 | Sync in progress; decode must stall |
| pfq_flush | output | 1 | Discard the prefetch queue |
| unc_abort | output | 1 | Abort outstanding uncacheable fetches on the bus |
| cur_gen | output | GW | Generation tag for new fetch requests |
| rsp_valid | input | 1 | Fetch response present |
| rsp_cacheable | input | 1 | Response belongs to a cacheable fill |
| rsp_gen | input | GW | Generation the request was tagged with |
| rsp_data | input | DW | Response data |
| rsp_fwd_valid | output | 1 | Response passed on to decode |
| rsp_fwd_data | output | DW | Forwarded data |
| redirect_valid | output | 1 | Restart fetch |
| redirect_pc | output | AW | Fetch restart address |

## Verification
Ready, busy, issue gating and response forwarding are combinational in the current phase and inputs. They are due in the same cycle as their stimulus. The flush/abort pulse is due one cycle after the first drain cycle with a zero count. The redirect is due one cycle after the flush, and the generation changes at the edge that closes the flush cycle. The bench drives inputs on the falling edge, lets them settle, and compares every output against a phase model that it advances on the rising edge. Each result is therefore checked in exactly the cycle in which it is due.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_DRAIN = 2'd1,
    FS_FLUSH = 2'd2,
    FS_REDIR = 2'd3
  } fs_state_e;
endpackage

// File: rtl/fsc_seq.sv
module fsc_seq
  import fsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int GW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [AW-1:0] pc_i,
  input  logic [CW-1:0] cnt_i,
  output fs_state_e     state_o,
  output logic [AW-1:0] pc_q_o,
  output logic [GW-1:0] gen_o
);
  function automatic logic [GW-1:0] gen_bump(input logic [GW-1:0] g);
    return g + GW'(1);
  endfunction

  fs_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      FS_IDLE:  if (accept_i) state_d = FS_DRAIN;
      FS_DRAIN: if (cnt_i == '0) state_d = FS_FLUSH;
      FS_FLUSH: state_d = FS_REDIR;
      FS_REDIR: state_d = FS_IDLE;
      default:  state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= FS_IDLE;
      pc_q_o  <= '0;
      gen_o   <= '0;
    end else begin
      state_o <= state_d;
      if (accept_i) pc_q_o <= pc_i;
      if (state_o == FS_FLUSH) gen_o <= gen_bump(gen_o);
    end
  end
endmodule

// File: rtl/fsc_rsp_filter.sv
module fsc_rsp_filter #(
  parameter int GW = 2,
  parameter int DW = 32
) (
  input  logic          rsp_valid_i,
  input  logic          rsp_cacheable_i,
  input  logic [GW-1:0] rsp_gen_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic [GW-1:0] cur_gen_i,
  input  logic          flushing_i,
  output logic          fwd_valid_o,
  output logic [DW-1:0] fwd_data_o,
  output logic          drop_o
);
  function automatic logic is_stale(input logic cacheable, input logic [GW-1:0] g,
                                    input logic [GW-1:0] cur, input logic flushing);
    return !cacheable && ((g != cur) || flushing);
  endfunction

  assign drop_o      = rsp_valid_i && is_stale(rsp_cacheable_i, rsp_gen_i, cur_gen_i, flushing_i);
  assign fwd_valid_o = rsp_valid_i && !drop_o;
  assign fwd_data_o  = fwd_valid_o ? rsp_data_i : '0;
endmodule

// File: rtl/fetch_sync_ctrl.sv
module fetch_sync_ctrl
  import fsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int GW = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_req_valid,
  input  logic [AW-1:0] sync_req_pc,
  output logic          sync_req_ready,
  input  logic [CW-1:0] inflight_cnt,
  input  logic          issue_valid,
  output logic          issue_ok,
  output logic          sync_busy,
  output logic          pfq_flush,
  output logic          unc_abort,
  output logic [GW-1:0] cur_gen,
  input  logic          rsp_valid,
  input  logic          rsp_cacheable,
  input  logic [GW-1:0] rsp_gen,
  input  logic [DW-1:0] rsp_data,
  output logic          rsp_fwd_valid,
  output logic [DW-1:0] rsp_fwd_data,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  function automatic logic [AW-1:0] next_pc(input logic [AW-1:0] pc);
    return pc + INSN_BYTES;
  endfunction

  fs_state_e     state;
  logic [AW-1:0] held_pc;
  logic          accept_evt;
  logic          drain_active;
  logic          flush_evt;
  logic          drop_evt;

  assign sync_req_ready = (state == FS_IDLE);
  assign accept_evt     = sync_req_valid && sync_req_ready;
  assign drain_active   = (state == FS_DRAIN);
  assign flush_evt      = (state == FS_FLUSH);

  fsc_seq #(.AW(AW), .CW(CW), .GW(GW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_evt),
    .pc_i     (sync_req_pc),
    .cnt_i    (inflight_cnt),
    .state_o  (state),
    .pc_q_o   (held_pc),
    .gen_o    (cur_gen)
  );

  fsc_rsp_filter #(.GW(GW), .DW(DW)) u_filt (
    .rsp_valid_i     (rsp_valid),
    .rsp_cacheable_i (rsp_cacheable),
    .rsp_gen_i       (rsp_gen),
    .rsp_data_i      (rsp_data),
    .cur_gen_i       (cur_gen),
    .flushing_i      (flush_evt),
    .fwd_valid_o     (rsp_fwd_valid),
    .fwd_data_o      (rsp_fwd_data),
    .drop_o          (drop_evt)
  );

  assign sync_busy      = (state != FS_IDLE) || sync_req_valid;
  assign issue_ok       = issue_valid && !sync_busy;
  assign pfq_flush      = flush_evt;
  assign unc_abort      = flush_evt;
  assign redirect_valid = (state == FS_REDIR);
  assign redirect_pc    = next_pc(held_pc);
endmodule

// File: rtl/fetch_sync_chk.sv
module fetch_sync_chk #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int GW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_req_ready,
  input logic          sync_busy,
  input logic          issue_ok,
  input logic          drain_active,
  input logic [CW-1:0] inflight_cnt,
  input logic          pfq_flush,
  input logic          unc_abort,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_pc,
  input logic [GW-1:0] cur_gen,
  input logic          rsp_valid,
  input logic          rsp_cacheable,
  input logic [GW-1:0] rsp_gen,
  input logic          rsp_fwd_valid,
  input logic          drop_evt
);
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid || pfq_flush || drain_active) |-> !sync_req_ready);

  p_busy_blocks_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy |-> !issue_ok);

  p_drain_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && inflight_cnt != '0) |=> !pfq_flush);

  p_flush_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pfq_flush |=> !pfq_flush);

  p_abort_with_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && inflight_cnt == '0) |=> (pfq_flush && unc_abort));

  p_redirect_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pfq_flush |=> (redirect_valid && $stable(redirect_pc)));

  p_gen_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pfq_flush |=> (cur_gen == GW'($past(cur_gen) + 1'b1)));

  p_gen_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pfq_flush |=> $stable(cur_gen));

  p_stale_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_cacheable && rsp_gen != cur_gen) |-> (!rsp_fwd_valid && drop_evt));

  p_fill_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cacheable) |-> rsp_fwd_valid);
endmodule

bind fetch_sync_ctrl fetch_sync_chk #(.AW(AW), .CW(CW), .GW(GW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sync_req_ready (sync_req_ready),
  .sync_busy      (sync_busy),
  .issue_ok       (issue_ok),
  .drain_active   (drain_active),
  .inflight_cnt   (inflight_cnt),
  .pfq_flush      (pfq_flush),
  .unc_abort      (unc_abort),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .cur_gen        (cur_gen),
  .rsp_valid      (rsp_valid),
  .rsp_cacheable  (rsp_cacheable),
  .rsp_gen        (rsp_gen),
  .rsp_fwd_valid  (rsp_fwd_valid),
  .drop_evt       (drop_evt)
);

// File: tb/fetch_sync_ctrl_tb.sv
module fetch_sync_ctrl_tb;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int GW = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_req_valid = 1'b0;
  logic [AW-1:0] sync_req_pc = '0;
  logic          sync_req_ready;
  logic [CW-1:0] inflight_cnt = '0;
  logic          issue_valid = 1'b0;
  logic          issue_ok;
  logic          sync_busy;
  logic          pfq_flush;
  logic          unc_abort;
  logic [GW-1:0] cur_gen;
  logic          rsp_valid = 1'b0;
  logic          rsp_cacheable = 1'b0;
  logic [GW-1:0] rsp_gen = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          rsp_fwd_valid;
  logic [DW-1:0] rsp_fwd_data;
  logic          redirect_valid;
  logic [AW-1:0] redirect_pc;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // bench phase model: 0 idle, 1 drain, 2 flush, 3 redirect
  int            m_phase = 0;
  logic [AW-1:0] m_pc    = '0;
  logic [GW-1:0] m_gen   = '0;

  always #2 clk = ~clk;  // 250 MHz

  fetch_sync_ctrl #(.AW(AW), .CW(CW), .GW(GW), .DW(DW)) u_dut (.*);

  function automatic logic [AW-1:0] exp_target(input logic [AW-1:0] pc);
    logic [AW:0] wide;
    wide = {1'b0, pc} + (AW+1)'(4);
    return wide[AW-1:0];
  endfunction

  function automatic logic exp_fwd(input logic v, input logic c, input logic [GW-1:0] g,
                                   input logic [GW-1:0] gen, input int phase);
    if (!v) return 1'b0;
    if (c) return 1'b1;
    return (g == gen) && (phase != 2);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_pc = '0; m_gen = '0;
    end else begin
      case (m_phase)
        0: if (sync_req_valid) begin m_pc = sync_req_pc; m_phase = 1; end
        1: if (inflight_cnt == '0) m_phase = 2;
        2: begin m_gen = m_gen + 1'b1; m_phase = 3; end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic compare_all();
    logic busy_e, fwd_e;
    busy_e = (m_phase != 0) || sync_req_valid;
    fwd_e  = exp_fwd(rsp_valid, rsp_cacheable, rsp_gen, m_gen, m_phase);
    check("R1 ready", 64'(sync_req_ready), 64'(m_phase == 0));
    check("R2 busy", 64'(sync_busy), 64'(busy_e));
    check("R2 issue", 64'(issue_ok), 64'(issue_valid && !busy_e));
    if (m_phase == 1) check("R3 no flush in drain", 64'(pfq_flush), 64'd0);
    check("R4 flush", 64'(pfq_flush), 64'(m_phase == 2));
    check("R4 abort", 64'(unc_abort), 64'(m_phase == 2));
    check("R5 redirect valid", 64'(redirect_valid), 64'(m_phase == 3));
    if (m_phase == 3) check("R5 redirect pc", 64'(redirect_pc), 64'(exp_target(m_pc)));
    check("R6 gen", 64'(cur_gen), 64'(m_gen));
    if (rsp_valid && !rsp_cacheable) check("R7 uncacheable fwd", 64'(rsp_fwd_valid), 64'(fwd_e));
    if (rsp_valid && rsp_cacheable) check("R8 cacheable fwd", 64'(rsp_fwd_valid), 64'(fwd_e));
    if (fwd_e) check("R8 data", 64'(rsp_fwd_data), 64'(rsp_data));
  endtask

  task automatic step(input logic rv, input logic [AW-1:0] rpc, input logic [CW-1:0] cnt,
                      input logic sv, input logic sc, input logic [GW-1:0] sg,
                      input logic [DW-1:0] sd, input logic iv);
    @(negedge clk);
    sync_req_valid = rv; sync_req_pc = rpc; inflight_cnt = cnt;
    rsp_valid = sv; rsp_cacheable = sc; rsp_gen = sg; rsp_data = sd; issue_valid = iv;
    #1;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 ready", 64'(sync_req_ready), 64'd1);
    check("R9 busy", 64'(sync_busy), 64'd0);
    check("R9 flush", 64'(pfq_flush), 64'd0);
    check("R9 abort", 64'(unc_abort), 64'd0);
    check("R9 redirect", 64'(redirect_valid), 64'd0);
    check("R9 gen", 64'(cur_gen), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: wrap-around target, drain of 3 cycles, second request while busy (R1)
    step(1, 32'hFFFF_FFFC, 4'd2, 0, 0, 0, 0, 1);
    step(1, 32'h0000_1000, 4'd2, 1, 0, 2'd1, 32'hDEAD_0001, 1);  // stale uncacheable R7
    step(1, 32'h0000_2000, 4'd1, 1, 1, 2'd3, 32'hCAFE_0002, 1);  // cacheable any gen R8
    step(0, 32'h0, 4'd0, 1, 0, 2'd0, 32'hBEEF_0003, 0);          // current gen passes
    step(1, 32'h0000_3000, 4'd0, 1, 0, 2'd0, 32'hBAD0_0004, 1);  // flush cycle drops R7
    step(0, 32'h0, 4'd0, 1, 1, 2'd0, 32'h1234_0005, 1);          // redirect to 0 R5
    check("R5 wrap target", 64'(redirect_pc), 64'h0);
    step(0, 32'h0, 4'd0, 1, 0, 2'd0, 32'hBAD0_0006, 1);          // old gen now stale
    check("R6 gen after flush", 64'(cur_gen), 64'd1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic rv, sv, sc, iv;
      logic [CW-1:0] cnt;
      rv  = ($urandom_range(0, 7) == 0);
      cnt = ($urandom_range(0, 1) == 0) ? '0 : CW'($urandom_range(1, 3));
      sv  = $urandom_range(0, 1) == 1;
      sc  = $urandom_range(0, 1) == 1;
      iv  = $urandom_range(0, 1) == 1;
      step(rv, {$urandom_range(0, 32'hFFFF) , 16'h0} | AW'($urandom_range(0, 15) << 2), cnt,
           sv, sc, GW'($urandom_range(0, 3)), $urandom, iv);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule